// File: doc/BRIEF.md
# Two-Task Paged Memory Mapper

This block sits between a CPU with a 16-bit address bus and a 512 KB RAM. It turns each logical address into a 19-bit physical address. The logical space is cut into eight 8 KB pages. The top three logical bits pick a page entry, which holds a 6-bit physical block number. Two complete sets of eight entries exist, and a task-select control picks the set used for translation. A system can therefore switch between two address spaces by flipping one bit.

Two windows skip the page entries altogether. The top 256 bytes of the logical space are always routed to I/O. When the vector-page control is set, the 256 bytes just below the I/O window always land on a fixed physical page near the top of RAM. When translation is off, or the legacy-compatibility control is set, every logical address maps straight into the top 64 KB of RAM.

All sixteen entries can be written and read back through a small register port. Translation is purely combinational from the logical address, the control inputs and the stored entries.

Top module: `pgmap_top`

## Requirements
- R1: With translation active (map_en=1, compat_mode=0) and neither window hit, phys_addr[18:13] equals the entry selected by task_sel and log_addr[15:13], and phys_addr[12:0] equals log_addr[12:0].
- R2: task_sel=0 selects entry set 0 and task_sel=1 selects entry set 1; the two sets are independent storage.
- R3: When acc_valid=1 and log_addr[15:8]=8'hFF, io_sel=1 and ram_sel=0 in every mode, and phys_addr equals {3'b111, log_addr}.
- R4: When vec_en=1 and log_addr[15:8]=8'hFE, phys_addr equals 19'h7FE00 plus log_addr[7:0], whatever the page entry holds.
- R5: When vec_en=0, logical addresses FE00 to FEFF translate through the page entry like any other address in page 7.
- R6: When map_en=0, phys_addr equals {3'b111, log_addr} for every address.
- R7: When compat_mode=1, phys_addr equals {3'b111, log_addr} even when map_en=1.
- R8: Synchronous active-high reset loads every entry of both sets with 56 plus its page index (page 0 gets 56, page 7 gets 63).
- R9: A write on reg_we with reg_addr={task, page} (bit 3 is the task, bits 2:0 the page) stores reg_wdata at the next rising edge; reg_rdata shows the addressed entry, and no other entry changes.
- R10: With acc_valid=0, ram_sel and io_sel are both 0; with acc_valid=1, exactly one of them is 1.
- R11: phys_addr, ram_sel and io_sel follow a change of log_addr or of the control inputs in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | CPU access in progress this cycle |
| log_addr | input | 16 | CPU logical address |
| map_en | input | 1 | Translation enable |
| compat_mode | input | 1 | Legacy mode; forces direct mapping |
| vec_en | input | 1 | Fixed vector page enable |
| task_sel | input | 1 | Active entry set |
| reg_we | input | 1 | Entry write strobe |
| reg_addr | input | 4 | Entry index {task, page} |
| reg_wdata | input | 6 | Block number to write |
| reg_rdata | output | 6 | Block number held by the addressed entry |
| phys_addr | output | 19 | Physical address |
| ram_sel | output | 1 | Access goes to RAM |
| io_sel | output | 1 | Access goes to the I/O window |

## Verification
The bench goes after the overlaps between windows and modes. It checks the I/O window while paging is on and while it is off: a design that ranked the page entry above the I/O decode would send register accesses into RAM. It checks the vector page with the page-7 entry loaded with a conflicting value, and with the vector enable cleared, so an override that is stuck on or dead shows up as a wrong block number. It also writes to one task set and reads the same page of the other set, which exposes a write decode that ignores the task bit, and it checks compatibility mode with translation enabled, which catches a bypass that looks only at the enable.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int LOG_W      = 16;
    localparam int PAGE_IDX_W = 3;
    localparam int NUM_PAGES  = 1 << PAGE_IDX_W;
    localparam int OFF_W      = LOG_W - PAGE_IDX_W;
    localparam int BLK_W      = 6;
    localparam int PHYS_W     = BLK_W + OFF_W;
    localparam int DIRECT_W   = PHYS_W - LOG_W;
    localparam int TASK_W     = 1;
    localparam int NUM_TASKS  = 1 << TASK_W;
    localparam int REG_IDX_W  = TASK_W + PAGE_IDX_W;
    localparam int RESET_BASE = (1 << BLK_W) - NUM_PAGES;
    localparam int HI_W       = 8;

    localparam logic [HI_W-1:0] IO_HI  = 8'hFF;
    localparam logic [HI_W-1:0] VEC_HI = 8'hFE;

    typedef enum logic [1:0] {
        ROUTE_IO     = 2'd0,
        ROUTE_VEC    = 2'd1,
        ROUTE_DIRECT = 2'd2,
        ROUTE_PAGED  = 2'd3
    } route_e;

    typedef struct packed {
        logic [PAGE_IDX_W-1:0] page;
        logic [OFF_W-1:0]      off;
    } laddr_t;

    // Priority: I/O window, then vector page, then direct, then paged.
    function automatic route_e pick_route(input logic [LOG_W-1:0] a,
                                          input logic vec_on,
                                          input logic direct);
        route_e r;
        if (a[LOG_W-1 -: HI_W] == IO_HI)
            r = ROUTE_IO;
        else if (vec_on && a[LOG_W-1 -: HI_W] == VEC_HI)
            r = ROUTE_VEC;
        else if (direct)
            r = ROUTE_DIRECT;
        else
            r = ROUTE_PAGED;
        return r;
    endfunction

    // Place a logical address in the top 64 KB of physical space.
    function automatic logic [PHYS_W-1:0] top_window(input logic [LOG_W-1:0] a);
        return {{DIRECT_W{1'b1}}, a};
    endfunction

    function automatic logic [BLK_W-1:0] reset_blk(input int page);
        return BLK_W'(RESET_BASE + page);
    endfunction

endpackage

// File: rtl/pgmap_regfile.sv
module pgmap_regfile
    import pgmap_pkg::*;
#(
    parameter int N_TASKS = NUM_TASKS,
    parameter int N_PAGES = NUM_PAGES,
    parameter int B_W     = BLK_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(N_TASKS*N_PAGES)-1:0] rw_idx,
    input  logic [B_W-1:0]                wr_data,
    output logic [B_W-1:0]                rd_data,
    input  logic [$clog2(N_TASKS)-1:0]    lk_task,
    input  logic [$clog2(N_PAGES)-1:0]    lk_page,
    output logic [B_W-1:0]                lk_blk
);
    localparam int N_ENT = N_TASKS * N_PAGES;
    localparam int IDX_W = $clog2(N_ENT);

    logic [B_W-1:0] ent_q [N_ENT];

    // Each entry is its own register with a page-derived reset value.
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam logic [B_W-1:0] INIT = B_W'(RESET_BASE + (i % N_PAGES));
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[i] <= INIT;
            else if (wr_en && rw_idx == IDX_W'(i))
                ent_q[i] <= wr_data;
        end
    end

    assign rd_data = ent_q[rw_idx];
    assign lk_blk  = ent_q[{lk_task, lk_page}];

    // Written value is visible on the read port one cycle later.
    assert_readback_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rw_idx != $past(rw_idx) || rd_data == $past(wr_data)));

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [LOG_W-1:0]      log_addr,
    input  logic                  map_en,
    input  logic                  compat_mode,
    input  logic                  vec_en,
    input  logic [BLK_W-1:0]      blk,
    output logic [PAGE_IDX_W-1:0] page_idx,
    output logic [PHYS_W-1:0]     phys_addr,
    output logic                  ram_sel,
    output logic                  io_sel
);
    laddr_t la;
    route_e route;
    logic   direct;

    always_comb begin
        la       = laddr_t'(log_addr);
        direct   = !map_en || compat_mode;
        route    = pick_route(log_addr, vec_en, direct);
        page_idx = la.page;
        unique case (route)
            ROUTE_PAGED: phys_addr = {blk, la.off};
            default:     phys_addr = top_window(log_addr);
        endcase
        io_sel  = acc_valid && (route == ROUTE_IO);
        ram_sel = acc_valid && (route != ROUTE_IO);
    end

    assert_io_window_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && log_addr[15:8] == 8'hFF) |-> (io_sel && !ram_sel));

    assert_vec_page_R4: assert property (@(posedge clk) disable iff (rst)
        (vec_en && log_addr[15:8] == 8'hFE) |->
            (phys_addr[PHYS_W-1:8] == 11'h7FE && phys_addr[7:0] == log_addr[7:0]));

    assert_direct_map_R6: assert property (@(posedge clk) disable iff (rst)
        (!map_en || compat_mode) |-> (phys_addr == {3'b111, log_addr}));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (map_en && !compat_mode) |-> (phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]));

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [LOG_W-1:0]     log_addr,
    input  logic                 map_en,
    input  logic                 compat_mode,
    input  logic                 vec_en,
    input  logic                 task_sel,
    input  logic                 reg_we,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [BLK_W-1:0]     reg_wdata,
    output logic [BLK_W-1:0]     reg_rdata,
    output logic [PHYS_W-1:0]    phys_addr,
    output logic                 ram_sel,
    output logic                 io_sel
);
    logic [PAGE_IDX_W-1:0] page_idx;
    logic [BLK_W-1:0]      lk_blk;

    pgmap_regfile #(
        .N_TASKS (NUM_TASKS),
        .N_PAGES (NUM_PAGES),
        .B_W     (BLK_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .rw_idx  (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .lk_task (task_sel),
        .lk_page (page_idx),
        .lk_blk  (lk_blk)
    );

    pgmap_xlate u_xlate (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .log_addr    (log_addr),
        .map_en      (map_en),
        .compat_mode (compat_mode),
        .vec_en      (vec_en),
        .blk         (lk_blk),
        .page_idx    (page_idx),
        .phys_addr   (phys_addr),
        .ram_sel     (ram_sel),
        .io_sel      (io_sel)
    );

    assert_sel_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!ram_sel && !io_sel));

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ($countones({ram_sel, io_sel}) == 1));

endmodule

// File: tb/pgmap_top_tb.sv
module pgmap_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [15:0] log_addr;
    logic        map_en, compat_mode, vec_en, task_sel;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [5:0]  reg_wdata;
    logic [5:0]  reg_rdata;
    logic [18:0] phys_addr;
    logic        ram_sel, io_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the entries, built from R8 and R9.
    logic [5:0] model [16];

    always #5 clk = ~clk;

    pgmap_top u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .log_addr(log_addr),
        .map_en(map_en), .compat_mode(compat_mode), .vec_en(vec_en),
        .task_sel(task_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phys_addr(phys_addr),
        .ram_sel(ram_sel), .io_sel(io_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_entry(logic [3:0] idx, logic [5:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic set_mode(logic me, logic cm, logic ve, logic ts);
        map_en = me; compat_mode = cm; vec_en = ve; task_sel = ts;
    endtask

    function automatic logic [18:0] paged(logic ts, logic [15:0] a);
        return {model[{ts, a[15:13]}], a[12:0]};
    endfunction

    task automatic probe(logic [15:0] a);
        log_addr = a;
        #1;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) begin
            reg_addr = 4'(i);
            #1;
            check("R8 reset entry", 32'(reg_rdata), 32'(56 + (i % 8)));
        end
    endtask

    task automatic t_translate;
        set_mode(1, 0, 0, 0);
        write_entry(4'h0, 6'h1A);
        probe(16'h1001);
        check("R1 block 1A offset 1001", 32'(phys_addr), 32'h35001);
        check("R1 ram_sel", 32'(ram_sel), 32'd1);
        probe(16'hA123);
        check("R1 reset entry page5", 32'(phys_addr), 32'(paged(0, 16'hA123)));
    endtask

    task automatic t_tasks;
        write_entry(4'h8, 6'h05);
        set_mode(1, 0, 0, 1);
        probe(16'h0042);
        check("R2 task1 page0", 32'(phys_addr), 32'h0A042);
        task_sel = 1'b0;
        #1;
        check("R2 task0 page0", 32'(phys_addr), 32'h34042);
    endtask

    task automatic t_io;
        set_mode(1, 0, 1, 0);
        probe(16'hFF23);
        check("R3 io_sel paged", 32'(io_sel), 32'd1);
        check("R3 ram_sel paged", 32'(ram_sel), 32'd0);
        check("R3 phys io", 32'(phys_addr), 32'h7FF23);
        set_mode(0, 1, 0, 1);
        #1;
        check("R3 io_sel direct", 32'({io_sel, ram_sel}), 32'b10);
    endtask

    task automatic t_vec;
        write_entry(4'h7, 6'h00);
        set_mode(1, 0, 1, 0);
        probe(16'hFE10);
        check("R4 vector page", 32'(phys_addr), 32'h7FE10);
        probe(16'hFD10);
        check("R4 below vector uses entry", 32'(phys_addr), 32'h01D10);
        vec_en = 1'b0;
        probe(16'hFE10);
        check("R5 vector off translates", 32'(phys_addr), 32'h01E10);
    endtask

    task automatic t_direct;
        set_mode(0, 0, 0, 0);
        probe(16'h1234);
        check("R6 map off", 32'(phys_addr), 32'h71234);
        set_mode(1, 1, 0, 0);
        #1;
        check("R7 compat with map on", 32'(phys_addr), 32'h71234);
        set_mode(1, 0, 0, 0);
        #1;
        check("R11 same-cycle mode change", 32'(phys_addr), 32'(paged(0, 16'h1234)));
    endtask

    task automatic t_valid;
        acc_valid = 1'b0;
        probe(16'h2000);
        check("R10 idle ram_sel", 32'(ram_sel), 32'd0);
        probe(16'hFF00);
        check("R10 idle io_sel", 32'(io_sel), 32'd0);
        acc_valid = 1'b1;
        #1;
        check("R10 active one select", 32'({io_sel, ram_sel}), 32'b10);
    endtask

    task automatic t_isolation;
        write_entry(4'hB, 6'h2A);
        reg_addr = 4'hB;
        #1;
        check("R9 readback task1 page3", 32'(reg_rdata), 32'h2A);
        reg_addr = 4'h3;
        #1;
        check("R9 task0 page3 untouched", 32'(reg_rdata), 32'd59);
        set_mode(1, 0, 0, 1);
        probe(16'h6007);
        check("R11 new address same cycle", 32'(phys_addr), 32'(paged(1, 16'h6007)));
        check("R9 task1 lookup", 32'(phys_addr), 32'h54007);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 6'(56 + (i % 8));
        rst = 1'b1; acc_valid = 1'b1; log_addr = 16'h0000;
        set_mode(0, 0, 0, 0);
        reg_we = 1'b0; reg_addr = 4'h0; reg_wdata = 6'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_translate();
        t_tasks();
        t_io();
        t_vec();
        t_direct();
        t_valid();
        t_isolation();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule